// File: doc/BRIEF.md
# Dual-Core Mailbox and Reset Controller

This block is the control unit beside a pair of processor cores. Each core has its own register port, and through it can reach five words: a core-control word, a status word, an entry/mask word and one 32-bit mailbox per core. A core signals the other by OR-ing action bits into the target mailbox. A nonzero write marks that mailbox as pending. While the target's mask bit is set, the pending flag drives that core's mailbox interrupt line. The receiving core reads its mailbox, writes it back to zero, and then clears its pending flag through the status word.

The same block holds the per-core reset lines. After power-on reset the second core is held in reset. Software programs a 64 KiB-aligned entry address and chooses, per core, whether that core starts there or at the fixed default vector, and then lets the core out of reset. It also drives a sleep-request line per core. It reports each core's sleep state and general interrupt inputs in the status word, and gates the general interrupts with their own mask bits.

Map (3-bit word address): 0 control, 1 status, 2 entry/mask, 3 mailbox of core 0, 4 mailbox of core 1. Control bits: [1:0] reset hold, [9:8] entry select, [17:16] sleep request. Status bits: [1:0] mailbox pending, [9:8] general interrupt inputs, [17:16] sleep inputs. Entry/mask bits: [31:16] entry address upper half, [1:0] mailbox interrupt enable, [9:8] general interrupt enable.

Top module: `core_pair_ctl`

## Requirements
- R1: After reset the control word reads 32'h0000_0002, so core 1 is held in reset and core 0 is released. The entry/mask word, both mailboxes and both pending flags read zero.
- R2: A write to mailbox address 3+i stores all 32 data bits, which read back unchanged from that address. A zero write empties the mailbox.
- R3: A write of a nonzero value to mailbox address 3+i, from either port, sets status bit i, and the flag reads as set on the cycle after the write. A zero write does not set it.
- R4: A write to the status word clears pending bit i where data bit i is 0 and keeps it where data bit i is 1. If a set for bit i happens in the same cycle, the set wins.
- R5: Status bits [9:8] show the gen_irq_in lines and bits [17:16] show the sleep_in lines, live. Writes to the status word never change them.
- R6: mbox_irq[i] is high exactly when pending bit i and entry/mask bit i are both 1.
- R7: gen_irq[i] equals gen_irq_in[i] AND entry/mask bit 8+i.
- R8: core_rst[i] equals control bit i. A core stays in reset while that bit is 1.
- R9: start_addr of core i is {entry/mask[31:16], 16'h0000} when control bit 8+i is 1, and 32'hBFC0_0000 otherwise.
- R10: sleep_req[i] equals control bit 16+i.
- R11: When both ports write the same register in one cycle, port 0's data is taken. Bits outside the defined fields (control mask 32'h0003_0303, entry/mask 32'hFFFF_0303) are dropped and read as zero.
- R12: Each port's bus_rdata shows the word at its own bus_raddr in the same cycle. Addresses 5 to 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | N_CORE | Write strobe per port |
| bus_waddr | input | N_CORE*3 | Write word address per port |
| bus_wdata | input | N_CORE*32 | Write data per port |
| bus_raddr | input | N_CORE*3 | Read word address per port |
| bus_rdata | output | N_CORE*32 | Read data per port, combinational |
| gen_irq_in | input | N_CORE | General interrupt request per core |
| sleep_in | input | N_CORE | Sleep indication per core |
| mbox_irq | output | N_CORE | Mailbox interrupt per core |
| gen_irq | output | N_CORE | Masked general interrupt per core |
| core_rst | output | N_CORE | Reset hold per core, active high |
| sleep_req | output | N_CORE | Sleep request per core |
| start_addr | output | N_CORE*32 | Start address per core |

## Verification
The properties assume that the bus strobes, addresses and data, and the gen_irq_in and sleep_in lines, are synchronous to clk and settle well before each rising edge. The bench therefore changes every input only at the falling edge. Any address value, including the unmapped ones, is legal on either port, so the random stimulus covers the whole 3-bit range on both ports. The random stimulus also produces same-cycle collisions: both ports writing one register, and a set racing a clear on one pending flag. Directed steps force each such collision once.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  // word addresses; mailbox i sits at ADR_MB_BASE + i
  localparam logic [AW-1:0] ADR_CTL  = 3'd0;
  localparam logic [AW-1:0] ADR_STAT = 3'd1;
  localparam logic [AW-1:0] ADR_VEC  = 3'd2;
  localparam int            ADR_MB_BASE = 3;

  // control word fields (lsb of per-core group)
  localparam int RST_LSB  = 0;
  localparam int SEL_LSB  = 8;
  localparam int SLPC_LSB = 16;

  // status word fields
  localparam int PEND_LSB = 0;
  localparam int GIN_LSB  = 8;
  localparam int SIN_LSB  = 16;

  // entry/mask word fields
  localparam int MMSK_LSB = 0;
  localparam int GMSK_LSB = 8;
  localparam int ENT_LSB  = 16;
  localparam int ENT_W    = 16;
endpackage

// File: rtl/cpc_rst_sync.sv
module cpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/cpc_ctlregs.sv
module cpc_ctlregs
  import cpc_pkg::*;
#(
  parameter int N = 2
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic [N-1:0]    we,
  input  logic [N*AW-1:0] waddr,
  input  logic [N*DW-1:0] wdata,
  output logic [DW-1:0]   ctl_q,
  output logic [DW-1:0]   vec_q
);
  localparam logic [DW-1:0] LOW_N     = DW'((1 << N) - 1);
  localparam logic [DW-1:0] CTL_WMASK = (LOW_N << RST_LSB) | (LOW_N << SEL_LSB) | (LOW_N << SLPC_LSB);
  localparam logic [DW-1:0] VEC_WMASK = (DW'((1 << ENT_W) - 1) << ENT_LSB) | (LOW_N << MMSK_LSB) | (LOW_N << GMSK_LSB);
  // every core except core 0 starts held in reset
  localparam logic [DW-1:0] CTL_RST   = (LOW_N & ~DW'(1)) << RST_LSB;

  logic [DW-1:0] ctl_d, vec_d;
  logic          ctl_en, vec_en;

  // next state: walk ports from highest to lowest so port 0 wins
  always_comb begin
    ctl_d  = ctl_q;
    vec_d  = vec_q;
    ctl_en = 1'b0;
    vec_en = 1'b0;
    for (int p = N - 1; p >= 0; p--) begin
      if (we[p] && (waddr[p*AW +: AW] == ADR_CTL)) begin
        ctl_d  = wdata[p*DW +: DW] & CTL_WMASK;
        ctl_en = 1'b1;
      end
      if (we[p] && (waddr[p*AW +: AW] == ADR_VEC)) begin
        vec_d  = wdata[p*DW +: DW] & VEC_WMASK;
        vec_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q <= CTL_RST;
      vec_q <= '0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      if (vec_en) vec_q <= vec_d;
    end
  end
endmodule

// File: rtl/cpc_mailbox.sv
module cpc_mailbox
  import cpc_pkg::*;
#(
  parameter int N = 2
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic [N-1:0]    we,
  input  logic [N*AW-1:0] waddr,
  input  logic [N*DW-1:0] wdata,
  output logic [N*DW-1:0] mb_flat,
  output logic [N-1:0]    pend
);
  for (genvar i = 0; i < N; i++) begin : g_box
    localparam logic [AW-1:0] MY_ADR = AW'(ADR_MB_BASE + i);

    logic [DW-1:0] mb_q, mb_d;
    logic          mb_en;
    logic          pend_q, pend_d;
    logic          set_ev, clr_ev;

    always_comb begin
      mb_d   = mb_q;
      mb_en  = 1'b0;
      set_ev = 1'b0;
      clr_ev = 1'b0;
      for (int p = N - 1; p >= 0; p--) begin
        if (we[p] && (waddr[p*AW +: AW] == MY_ADR)) begin
          mb_d  = wdata[p*DW +: DW];
          mb_en = 1'b1;
          if (wdata[p*DW +: DW] != '0) set_ev = 1'b1;
        end
        if (we[p] && (waddr[p*AW +: AW] == ADR_STAT) && !wdata[p*DW + PEND_LSB + i])
          clr_ev = 1'b1;
      end
      // a set in the same cycle as a clear takes precedence
      pend_d = set_ev | (pend_q & ~clr_ev);
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        mb_q   <= '0;
        pend_q <= 1'b0;
      end else begin
        if (mb_en) mb_q <= mb_d;
        if (set_ev || clr_ev) pend_q <= pend_d;
      end
    end

    assign mb_flat[i*DW +: DW] = mb_q;
    assign pend[i]             = pend_q;
  end
endmodule

// File: rtl/cpc_vecgen.sv
module cpc_vecgen
  import cpc_pkg::*;
#(
  parameter int            N       = 2,
  parameter logic [DW-1:0] DEF_VEC = 32'hBFC0_0000
) (
  input  logic [N-1:0]     sel,
  input  logic [ENT_W-1:0] entry,
  output logic [N*DW-1:0]  start_addr
);
  for (genvar i = 0; i < N; i++) begin : g_vec
    assign start_addr[i*DW +: DW] = sel[i] ? {entry, {(DW - ENT_W){1'b0}}} : DEF_VEC;
  end
endmodule

// File: rtl/core_pair_ctl.sv
module core_pair_ctl
  import cpc_pkg::*;
#(
  parameter int            N_CORE  = 2,
  parameter logic [DW-1:0] DEF_VEC = 32'hBFC0_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_CORE-1:0]    bus_we,
  input  logic [N_CORE*AW-1:0] bus_waddr,
  input  logic [N_CORE*DW-1:0] bus_wdata,
  input  logic [N_CORE*AW-1:0] bus_raddr,
  output logic [N_CORE*DW-1:0] bus_rdata,
  input  logic [N_CORE-1:0]    gen_irq_in,
  input  logic [N_CORE-1:0]    sleep_in,
  output logic [N_CORE-1:0]    mbox_irq,
  output logic [N_CORE-1:0]    gen_irq,
  output logic [N_CORE-1:0]    core_rst,
  output logic [N_CORE-1:0]    sleep_req,
  output logic [N_CORE*DW-1:0] start_addr
);
  logic                 srst_n;
  logic [DW-1:0]        ctl_q, vec_q, stat_w;
  logic [N_CORE*DW-1:0] mb_flat;
  logic [N_CORE-1:0]    pend;

  cpc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  cpc_ctlregs #(.N(N_CORE)) u_regs (
    .clk(clk), .srst_n(srst_n), .we(bus_we), .waddr(bus_waddr),
    .wdata(bus_wdata), .ctl_q(ctl_q), .vec_q(vec_q)
  );

  cpc_mailbox #(.N(N_CORE)) u_mbox (
    .clk(clk), .srst_n(srst_n), .we(bus_we), .waddr(bus_waddr),
    .wdata(bus_wdata), .mb_flat(mb_flat), .pend(pend)
  );

  cpc_vecgen #(.N(N_CORE), .DEF_VEC(DEF_VEC)) u_vec (
    .sel(ctl_q[SEL_LSB +: N_CORE]), .entry(vec_q[ENT_LSB +: ENT_W]),
    .start_addr(start_addr)
  );

  always_comb begin
    stat_w                     = '0;
    stat_w[PEND_LSB +: N_CORE] = pend;
    stat_w[GIN_LSB  +: N_CORE] = gen_irq_in;
    stat_w[SIN_LSB  +: N_CORE] = sleep_in;
  end

  for (genvar p = 0; p < N_CORE; p++) begin : g_rd
    logic [AW-1:0] ra;
    logic [DW-1:0] rd_w;
    assign ra = bus_raddr[p*AW +: AW];
    always_comb begin
      case (ra)
        ADR_CTL:  rd_w = ctl_q;
        ADR_STAT: rd_w = stat_w;
        ADR_VEC:  rd_w = vec_q;
        default:  rd_w = '0;
      endcase
      for (int i = 0; i < N_CORE; i++)
        if (ra == AW'(ADR_MB_BASE + i)) rd_w = mb_flat[i*DW +: DW];
    end
    assign bus_rdata[p*DW +: DW] = rd_w;
  end

  assign mbox_irq  = pend & vec_q[MMSK_LSB +: N_CORE];
  assign gen_irq   = gen_irq_in & vec_q[GMSK_LSB +: N_CORE];
  assign core_rst  = ctl_q[RST_LSB +: N_CORE];
  assign sleep_req = ctl_q[SLPC_LSB +: N_CORE];
endmodule

// File: rtl/cpc_chk.sv
module cpc_chk
  import cpc_pkg::*;
#(
  parameter int N = 2
) (
  input logic            clk,
  input logic            srst_n,
  input logic [N-1:0]    bus_we,
  input logic [N*AW-1:0] bus_waddr,
  input logic [N*DW-1:0] bus_wdata,
  input logic [N-1:0]    pend,
  input logic [N-1:0]    mmask,
  input logic [N-1:0]    mbox_irq,
  input logic [N-1:0]    core_rst,
  input logic [N*DW-1:0] start_addr
);
  logic ctl_wr, vec_wr;
  logic [N-1:0] set_ev, clr_ev;

  always_comb begin
    ctl_wr = 1'b0;
    vec_wr = 1'b0;
    set_ev = '0;
    clr_ev = '0;
    for (int p = 0; p < N; p++) begin
      if (bus_we[p] && bus_waddr[p*AW +: AW] == ADR_CTL) ctl_wr = 1'b1;
      if (bus_we[p] && bus_waddr[p*AW +: AW] == ADR_VEC) vec_wr = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (bus_we[p] && bus_waddr[p*AW +: AW] == AW'(ADR_MB_BASE + i) && bus_wdata[p*DW +: DW] != '0)
          set_ev[i] = 1'b1;
        if (bus_we[p] && bus_waddr[p*AW +: AW] == ADR_STAT && !bus_wdata[p*DW + PEND_LSB + i])
          clr_ev[i] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_core
    // R3
    pend_rise_src_chk: assert property (@(posedge clk) disable iff (!srst_n)
      $rose(pend[i]) |-> $past(set_ev[i]));
    // R4
    pend_fall_src_chk: assert property (@(posedge clk) disable iff (!srst_n)
      $fell(pend[i]) |-> $past(clr_ev[i] && !set_ev[i]));
    // R4
    pend_set_wins_chk: assert property (@(posedge clk) disable iff (!srst_n)
      $past(set_ev[i]) |-> pend[i]);
    // R6
    irq_gated_chk: assert property (@(posedge clk) disable iff (!srst_n)
      mbox_irq[i] |-> (pend[i] && mmask[i]));
  end

  // R8
  rst_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(ctl_wr) |-> $stable(core_rst));
  // R9
  vec_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(ctl_wr || vec_wr) |-> $stable(start_addr));
endmodule

bind core_pair_ctl cpc_chk #(.N(N_CORE)) u_chk (
  .clk(clk), .srst_n(srst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
  .bus_wdata(bus_wdata), .pend(pend), .mmask(vec_q[N_CORE-1:0]),
  .mbox_irq(mbox_irq), .core_rst(core_rst), .start_addr(start_addr)
);

// File: tb/core_pair_ctl_bench.sv
module core_pair_ctl_bench;
  localparam logic [31:0] CTL_M = 32'h0003_0303;
  localparam logic [31:0] VEC_M = 32'hFFFF_0303;
  localparam logic [31:0] DEFV  = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_we;
  logic [5:0]  bus_waddr, bus_raddr;
  logic [63:0] bus_wdata, bus_rdata, start_addr;
  logic [1:0]  gen_irq_in, sleep_in, mbox_irq, gen_irq, core_rst, sleep_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_ctl, m_vec, m_mb0, m_mb1;
  logic [1:0]  m_pend;

  always #5 clk = ~clk;

  core_pair_ctl u_core_pair_ctl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .gen_irq_in(gen_irq_in), .sleep_in(sleep_in), .mbox_irq(mbox_irq),
    .gen_irq(gen_irq), .core_rst(core_rst), .sleep_req(sleep_req),
    .start_addr(start_addr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ctl;
      3'd1: return {14'd0, sleep_in, 6'd0, gen_irq_in, 6'd0, m_pend};
      3'd2: return m_vec;
      3'd3: return m_mb0;
      3'd4: return m_mb1;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_start(input int i);
    return m_ctl[8+i] ? {m_vec[31:16], 16'h0} : DEFV;
  endfunction

  // drive at negedge, compare, advance model, wait one cycle
  task automatic step(input logic [1:0] we, input logic [2:0] a0, input logic [31:0] d0,
                      input logic [2:0] a1, input logic [31:0] d1,
                      input logic [2:0] r0, input logic [2:0] r1);
    bus_we = we; bus_waddr = {a1, a0}; bus_wdata = {d1, d0}; bus_raddr = {r1, r0};
    #1;
    chk("R12 port0 read", bus_rdata[31:0], exp_rd(r0));
    chk("R12 port1 read", bus_rdata[63:32], exp_rd(r1));
    chk("R6 mbox_irq", {30'd0, mbox_irq}, {30'd0, m_pend & m_vec[1:0]});
    chk("R7 gen_irq", {30'd0, gen_irq}, {30'd0, gen_irq_in & m_vec[9:8]});
    chk("R8 core_rst", {30'd0, core_rst}, {30'd0, m_ctl[1:0]});
    chk("R10 sleep_req", {30'd0, sleep_req}, {30'd0, m_ctl[17:16]});
    chk("R9 start core0", start_addr[31:0], exp_start(0));
    chk("R9 start core1", start_addr[63:32], exp_start(1));
    for (int i = 0; i < 2; i++) begin
      logic s, c;
      s = (we[0] && a0 == 3'(3 + i) && d0 != 0) || (we[1] && a1 == 3'(3 + i) && d1 != 0);
      c = (we[0] && a0 == 3'd1 && !d0[i]) || (we[1] && a1 == 3'd1 && !d1[i]);
      m_pend[i] = s | (m_pend[i] & ~c);
    end
    if (we[1] && a1 == 3'd0) m_ctl = d1 & CTL_M;
    if (we[0] && a0 == 3'd0) m_ctl = d0 & CTL_M;
    if (we[1] && a1 == 3'd2) m_vec = d1 & VEC_M;
    if (we[0] && a0 == 3'd2) m_vec = d0 & VEC_M;
    if (we[1] && a1 == 3'd3) m_mb0 = d1;
    if (we[0] && a0 == 3'd3) m_mb0 = d0;
    if (we[1] && a1 == 3'd4) m_mb1 = d1;
    if (we[0] && a0 == 3'd4) m_mb1 = d0;
    @(negedge clk);
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    bus_we = 2'b00; bus_raddr[2:0] = a;
    #1 v = bus_rdata[31:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_we = 0; bus_waddr = 0; bus_wdata = 0; bus_raddr = 0;
    gen_irq_in = 0; sleep_in = 0;
    m_ctl = 32'h2; m_vec = 0; m_mb0 = 0; m_mb1 = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 core_rst", {30'd0, core_rst}, 32'd2);
    peek(3'd0, v); chk("R1 ctl", v, 32'h2);
    peek(3'd2, v); chk("R1 entry/mask", v, 32'h0);
    peek(3'd3, v); chk("R1 mbox0", v, 32'h0);
    peek(3'd4, v); chk("R1 mbox1", v, 32'h0);
    peek(3'd1, v); chk("R1 status", v, 32'h0);
    chk("R1 mbox_irq", {30'd0, mbox_irq}, 32'd0);
    @(negedge clk);

    // R2 / R3 mailbox store and pending, masked
    step(2'b10, 0, 0, 3'd3, 32'hA5A5_0001, 0, 0);
    peek(3'd3, v); chk("R2 mbox0 value", v, 32'hA5A5_0001);
    peek(3'd1, v); chk("R3 pending0 set", v, 32'h1);
    chk("R6 masked irq low", {30'd0, mbox_irq}, 32'd0);
    @(negedge clk);

    // R11 field mask on entry/mask, R6 enable
    step(2'b01, 3'd2, 32'h1234_FFFF, 0, 0, 0, 0);
    peek(3'd2, v); chk("R11 entry/mask masked", v, 32'h1234_0303);
    chk("R6 irq on", {30'd0, mbox_irq}, 32'd1);
    @(negedge clk);

    // R4 write ones keeps, set beats clear, clear alone
    step(2'b01, 3'd1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    peek(3'd1, v); chk("R4 ones keep", v, 32'h1);
    @(negedge clk);
    step(2'b11, 3'd1, 32'h0, 3'd3, 32'h4, 0, 0);
    peek(3'd1, v); chk("R4 set wins", v, 32'h1);
    @(negedge clk);
    step(2'b01, 3'd1, 32'h0, 0, 0, 0, 0);
    peek(3'd1, v); chk("R4 cleared", v, 32'h0);
    chk("R4 irq dropped", {30'd0, mbox_irq}, 32'd0);
    @(negedge clk);

    // R3 zero write sets nothing; R2 zero write empties
    step(2'b11, 3'd3, 32'h0, 3'd4, 32'h0, 0, 0);
    peek(3'd1, v); chk("R3 zero write no set", v, 32'h0);
    peek(3'd3, v); chk("R2 zero empties", v, 32'h0);
    @(negedge clk);

    // R11 port priority on control
    step(2'b11, 3'd0, 32'h0000_0100, 3'd0, 32'h0003_0302, 0, 0);
    peek(3'd0, v); chk("R11 port0 wins", v, 32'h100);
    chk("R8 both released", {30'd0, core_rst}, 32'd0);
    chk("R9 core0 entry", start_addr[31:0], 32'h1234_0000);
    chk("R9 core1 default", start_addr[63:32], DEFV);
    @(negedge clk);

    // R5 live status inputs, untouched by writes
    gen_irq_in = 2'b10; sleep_in = 2'b01;
    step(2'b01, 3'd1, 32'h0, 0, 0, 0, 0);
    peek(3'd1, v); chk("R5 live inputs", v, 32'h0001_0200);
    chk("R7 gated general", {30'd0, gen_irq}, 32'd2);
    @(negedge clk);

    // R12 unmapped address
    step(2'b01, 3'd5, 32'hFFFF_FFFF, 0, 0, 0, 0);
    peek(3'd5, v); chk("R12 unmapped reads zero", v, 32'h0);
    peek(3'd0, v); chk("R12 ctl unchanged", v, 32'h100);
    @(negedge clk);

    // R10 sleep request
    step(2'b10, 0, 0, 3'd0, 32'h0003_0000, 0, 0);
    chk("R10 sleep_req", {30'd0, sleep_req}, 32'd3);
    @(negedge clk);

    // random mix, model-checked every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] d0, d1;
      d0 = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      d1 = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      gen_irq_in = 2'($urandom);
      sleep_in   = 2'($urandom);
      step(2'($urandom), 3'($urandom), d0, 3'($urandom), d1, 3'($urandom), 3'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule